// File: doc/BRIEF.md
# Memory-Reference Instruction Sequencer

This block drives the execute phase of the seven memory-reference instructions of a 16-bit accumulator machine. Fetch and decode happen elsewhere and have already placed the operand address in AR. The block watches the one-hot operation lines and the step signals T0, T4, T5 and T6. From them it raises the strobes that move data between memory and the DR, AC, PC and AR registers. It writes E on an add and tells the step counter when the instruction is complete.

The strobes for step T4 are decoded directly from the operation lines. At T4 the block also records which multi-step instruction is in flight in a small state register. Steps T5 and T6 are then driven from that record and not from the operation lines. The AC result is formed outside the block: `ac_op` selects the function and `ac_ld` loads it. The carry into E is computed here, because only this block knows when an add completes. A DR load always reads memory at the current AR.

The states are: IDLE (no instruction pending), AND_T5, ADD_T5, LDA_T5 (waiting to combine DR into AC), BSA_T5 (waiting to jump past the stored return word), ISZ_T5 (waiting to increment DR) and ISZ_T6 (waiting to write back and test). Transitions: IDLE goes to the matching state on T4 when D0, D1, D2, D5 or D6 is high. The three AC states and BSA_T5 return to IDLE on T5. ISZ_T5 moves to ISZ_T6 on T5. ISZ_T6 returns to IDLE on T6. Any state other than IDLE drops to IDLE on T0.

Top module: `memx_exec`

## Requirements
- R1: AND (op_sel bit 0): at T4, `dr_ld`. At T5, `ac_ld` with `ac_op`=01 (AC & DR) and `sc_clr`. The instruction takes two steps.
- R2: ADD (op_sel bit 1): at T4, `dr_ld`. At T5, `ac_ld` with `ac_op`=10 (AC + DR), `e_ld` with `e_din` equal to the carry out of bit 15, and `sc_clr`.
- R3: LDA (op_sel bit 2): at T4, `dr_ld`. At T5, `ac_ld` with `ac_op`=00 (AC takes DR) and `sc_clr`.
- R4: STA (op_sel bit 3): at T4 only, `mem_we` with `mem_wdata`=AC and `sc_clr`. The instruction takes one step and AC is left unchanged.
- R5: BUN (op_sel bit 4): at T4 only, `pc_ld` with `pc_din`=AR and `sc_clr`. `pc_ld` and `pc_inc` are never high together.
- R6: BSA (op_sel bit 5): at T4, `mem_we` with `mem_wdata` = the 12-bit PC zero-extended (bits 15..12 zero), plus `ar_inc`. At T5, `pc_ld` of the incremented AR and `sc_clr`. AR wraps from 0xFFF to 0x000.
- R7: ISZ (op_sel bit 6): at T4, `dr_ld`. At T5, `dr_inc`. At T6, `mem_we` with `mem_wdata`=DR, `sc_clr`, and `pc_inc` only when DR is zero. The instruction takes three steps.
- R8: at T4 with no op_sel bit high, no strobe is raised and the block stays idle.
- R9: out of reset the block is idle and every strobe is low.
- R10: T0 while an instruction is pending abandons it. The next instruction runs as if the abandoned one had never started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 7 | One-hot operation lines D0..D6 |
| t0 | input | 1 | Step T0 |
| t4 | input | 1 | Step T4 |
| t5 | input | 1 | Step T5 |
| t6 | input | 1 | Step T6 |
| ac | input | 16 | Current accumulator |
| dr | input | 16 | Current data register |
| pc | input | 12 | Current program counter |
| ar | input | 12 | Current address register |
| mem_we | output | 1 | Write mem_wdata to memory at AR |
| mem_wdata | output | 16 | Memory write data |
| dr_ld | output | 1 | Load DR from memory at AR |
| dr_inc | output | 1 | Increment DR |
| ac_ld | output | 1 | Load AC with the selected function |
| ac_op | output | 2 | AC function: 00 DR, 01 AND, 10 ADD |
| e_ld | output | 1 | Load E from e_din |
| e_din | output | 1 | Carry out of AC + DR |
| pc_ld | output | 1 | Load PC from pc_din |
| pc_inc | output | 1 | Increment PC |
| pc_din | output | 12 | PC load value (AR) |
| ar_inc | output | 1 | Increment AR |
| sc_clr | output | 1 | Clear the step counter |

## Verification
Each opcode runs against a register and memory model. Operands are chosen so that a wrong AC function or a stale opcode gives a different value. For AND, a pattern with partial bit overlap separates AND from OR and from plain transfer. For ADD, 0xFFFF + 2 and a carry-free sum show that E is written from the carry and not merely kept. BSA with PC 0xFFF at address 0xFFF exposes the zero upper bits and the AR wrap. ISZ on 0xFFFF and on 7 separates the skip from the no-skip case. An operation-free T4 and an ADD abandoned at T0 show that no strobe leaks and that no stale state survives.

// File: rtl/memx_pkg.sv
package memx_pkg;

    typedef enum logic [2:0] {
        MX_IDLE   = 3'd0,
        MX_AND_T5 = 3'd1,
        MX_ADD_T5 = 3'd2,
        MX_LDA_T5 = 3'd3,
        MX_BSA_T5 = 3'd4,
        MX_ISZ_T5 = 3'd5,
        MX_ISZ_T6 = 3'd6
    } mx_state_e;

    typedef enum logic [1:0] {
        ALU_DR  = 2'b00,
        ALU_AND = 2'b01,
        ALU_ADD = 2'b10
    } alu_sel_e;

    localparam int OP_AND = 0;
    localparam int OP_ADD = 1;
    localparam int OP_LDA = 2;
    localparam int OP_STA = 3;
    localparam int OP_BUN = 4;
    localparam int OP_BSA = 5;
    localparam int OP_ISZ = 6;
    localparam int OP_N   = 7;

endpackage

// File: rtl/memx_flags.sv
module memx_flags #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] ac,
    input  logic [DATA_W-1:0] dr,
    output logic              carry,
    output logic              dr_zero
);
    logic [DATA_W:0] cy;

    assign cy[0] = 1'b0;

    // Ripple carry only: the sum itself is formed in the AC logic outside.
    for (genvar i = 0; i < DATA_W; i++) begin : g_cy
        assign cy[i+1] = (ac[i] & dr[i]) | (cy[i] & (ac[i] ^ dr[i]));
    end

    assign carry   = cy[DATA_W];
    assign dr_zero = ~|dr;
endmodule

// File: rtl/memx_seq.sv
module memx_seq
    import memx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_N-1:0] op_sel,
    input  logic            t0,
    input  logic            t4,
    input  logic            t5,
    input  logic            t6,
    output mx_state_e       state
);
    mx_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            MX_IDLE: begin
                if (t4) begin
                    if      (op_sel[OP_AND]) nxt = MX_AND_T5;
                    else if (op_sel[OP_ADD]) nxt = MX_ADD_T5;
                    else if (op_sel[OP_LDA]) nxt = MX_LDA_T5;
                    else if (op_sel[OP_BSA]) nxt = MX_BSA_T5;
                    else if (op_sel[OP_ISZ]) nxt = MX_ISZ_T5;
                end
            end
            MX_AND_T5, MX_ADD_T5, MX_LDA_T5, MX_BSA_T5: begin
                if (t0)      nxt = MX_IDLE;
                else if (t5) nxt = MX_IDLE;
            end
            MX_ISZ_T5: begin
                if (t0)      nxt = MX_IDLE;
                else if (t5) nxt = MX_ISZ_T6;
            end
            MX_ISZ_T6: begin
                if (t0 || t6) nxt = MX_IDLE;
            end
            default: nxt = MX_IDLE;
        endcase
    end

    AST_OP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_sel)); // R8
    AST_T0_ABANDON: assert property (@(posedge clk) disable iff (!rst_n)
        t0 |=> state == MX_IDLE); // R10
    AST_ISZ_THIRD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MX_ISZ_T5 && t5 && !t0) |=> state == MX_ISZ_T6); // R7
    AST_NOOP_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MX_IDLE && t4 && op_sel == '0) |=> state == MX_IDLE); // R8
endmodule

// File: rtl/memx_strobes.sv
module memx_strobes
    import memx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mx_state_e         state,
    input  logic [OP_N-1:0]   op_sel,
    input  logic              t4,
    input  logic              t5,
    input  logic              t6,
    input  logic [DATA_W-1:0] ac,
    input  logic [DATA_W-1:0] dr,
    input  logic [ADDR_W-1:0] pc,
    input  logic              carry,
    input  logic              dr_zero,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              dr_ld,
    output logic              dr_inc,
    output logic              ac_ld,
    output alu_sel_e          ac_op,
    output logic              e_ld,
    output logic              e_din,
    output logic              pc_ld,
    output logic              pc_inc,
    output logic              ar_inc,
    output logic              sc_clr
);
    localparam int PAD_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] ret_word;
    assign ret_word = {{PAD_W{1'b0}}, pc};

    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = '0;
        dr_ld     = 1'b0;
        dr_inc    = 1'b0;
        ac_ld     = 1'b0;
        ac_op     = ALU_DR;
        e_ld      = 1'b0;
        e_din     = 1'b0;
        pc_ld     = 1'b0;
        pc_inc    = 1'b0;
        ar_inc    = 1'b0;
        sc_clr    = 1'b0;
        unique case (state)
            MX_IDLE: begin
                if (t4) begin
                    if (op_sel[OP_AND] || op_sel[OP_ADD] || op_sel[OP_LDA] || op_sel[OP_ISZ])
                        dr_ld = 1'b1;
                    if (op_sel[OP_STA]) begin
                        mem_we    = 1'b1;
                        mem_wdata = ac;
                        sc_clr    = 1'b1;
                    end
                    if (op_sel[OP_BUN]) begin
                        pc_ld  = 1'b1;
                        sc_clr = 1'b1;
                    end
                    if (op_sel[OP_BSA]) begin
                        mem_we    = 1'b1;
                        mem_wdata = ret_word;
                        ar_inc    = 1'b1;
                    end
                end
            end
            MX_AND_T5: if (t5) begin
                ac_ld  = 1'b1;
                ac_op  = ALU_AND;
                sc_clr = 1'b1;
            end
            MX_ADD_T5: if (t5) begin
                ac_ld  = 1'b1;
                ac_op  = ALU_ADD;
                e_ld   = 1'b1;
                e_din  = carry;
                sc_clr = 1'b1;
            end
            MX_LDA_T5: if (t5) begin
                ac_ld  = 1'b1;
                ac_op  = ALU_DR;
                sc_clr = 1'b1;
            end
            MX_BSA_T5: if (t5) begin
                pc_ld  = 1'b1;
                sc_clr = 1'b1;
            end
            MX_ISZ_T5: if (t5) dr_inc = 1'b1;
            MX_ISZ_T6: if (t6) begin
                mem_we    = 1'b1;
                mem_wdata = dr;
                pc_inc    = dr_zero;
                sc_clr    = 1'b1;
            end
            default: ;
        endcase
    end

    AST_PC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc_ld && pc_inc)); // R5
    AST_AC_ENDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ac_ld |-> (sc_clr && t5)); // R1
    AST_RET_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && ar_inc) |-> mem_wdata[DATA_W-1:ADDR_W] == '0); // R6
    AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && dr_ld)); // R7
    AST_E_ONLY_ON_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        e_ld |-> (ac_ld && ac_op == ALU_ADD)); // R2
endmodule

// File: rtl/memx_exec.sv
module memx_exec
    import memx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        op_sel,
    input  logic              t0,
    input  logic              t4,
    input  logic              t5,
    input  logic              t6,
    input  logic [DATA_W-1:0] ac,
    input  logic [DATA_W-1:0] dr,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] ar,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              dr_ld,
    output logic              dr_inc,
    output logic              ac_ld,
    output logic [1:0]        ac_op,
    output logic              e_ld,
    output logic              e_din,
    output logic              pc_ld,
    output logic              pc_inc,
    output logic [ADDR_W-1:0] pc_din,
    output logic              ar_inc,
    output logic              sc_clr
);
    mx_state_e state;
    alu_sel_e  alu_sel;
    logic      carry;
    logic      dr_zero;

    memx_flags #(.DATA_W(DATA_W)) u_flags (
        .ac      (ac),
        .dr      (dr),
        .carry   (carry),
        .dr_zero (dr_zero)
    );

    memx_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_sel (op_sel),
        .t0     (t0),
        .t4     (t4),
        .t5     (t5),
        .t6     (t6),
        .state  (state)
    );

    memx_strobes #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_strobes (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .op_sel    (op_sel),
        .t4        (t4),
        .t5        (t5),
        .t6        (t6),
        .ac        (ac),
        .dr        (dr),
        .pc        (pc),
        .carry     (carry),
        .dr_zero   (dr_zero),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .dr_ld     (dr_ld),
        .dr_inc    (dr_inc),
        .ac_ld     (ac_ld),
        .ac_op     (alu_sel),
        .e_ld      (e_ld),
        .e_din     (e_din),
        .pc_ld     (pc_ld),
        .pc_inc    (pc_inc),
        .ar_inc    (ar_inc),
        .sc_clr    (sc_clr)
    );

    assign ac_op  = alu_sel;
    assign pc_din = ar;
endmodule

// File: tb/memx_exec_test.sv
module memx_exec_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    // machine model
    logic [15:0] ac, dr, mem [0:4095];
    logic [11:0] pc, ar;
    logic        e, active;
    logic [3:0]  sc;
    logic [6:0]  cur_op;

    // preset path, driven only by the initial block
    logic        p_go = 1'b0, p_act = 1'b0, p_e = 1'b0;
    logic [15:0] p_ac = '0, p_dr = '0, p_mv = '0;
    logic [11:0] p_pc = '0, p_ar = '0;
    logic [6:0]  p_op = '0;

    logic        mem_we, dr_ld, dr_inc, ac_ld, e_ld, e_din, pc_ld, pc_inc, ar_inc, sc_clr;
    logic [15:0] mem_wdata;
    logic [1:0]  ac_op;
    logic [11:0] pc_din;
    logic        t0, t4, t5, t6;

    assign t0 = (sc == 4'd0);
    assign t4 = active && sc == 4'd4;
    assign t5 = active && sc == 4'd5;
    assign t6 = active && sc == 4'd6;

    memx_exec uut (
        .clk(clk), .rst_n(rst_n), .op_sel(cur_op),
        .t0(t0), .t4(t4), .t5(t5), .t6(t6),
        .ac(ac), .dr(dr), .pc(pc), .ar(ar),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .dr_ld(dr_ld), .dr_inc(dr_inc),
        .ac_ld(ac_ld), .ac_op(ac_op), .e_ld(e_ld), .e_din(e_din),
        .pc_ld(pc_ld), .pc_inc(pc_inc), .pc_din(pc_din), .ar_inc(ar_inc),
        .sc_clr(sc_clr)
    );

    initial begin
        sc = 4'd1; active = 1'b0; cur_op = '0;
        ac = '0; dr = '0; pc = '0; ar = '0; e = 1'b0;
    end

    always @(posedge clk) begin
        if (p_go) begin
            ac <= p_ac; dr <= p_dr; pc <= p_pc; ar <= p_ar; e <= p_e;
            mem[p_ar] <= p_mv;
            cur_op <= p_op;
            active <= p_act;
            sc <= p_act ? 4'd4 : 4'd0;
        end else if (active) begin
            if (mem_we) mem[ar] <= mem_wdata;
            if (dr_ld)  dr <= mem[ar];
            if (dr_inc) dr <= dr + 16'd1;
            if (ac_ld) begin
                case (ac_op)
                    2'b01:   ac <= ac & dr;
                    2'b10:   ac <= ac + dr;
                    default: ac <= dr;
                endcase
            end
            if (e_ld)   e <= e_din;
            if (pc_ld)  pc <= pc_din;
            if (pc_inc) pc <= pc + 12'd1;
            if (ar_inc) ar <= ar + 12'd1;
            if (sc_clr) begin sc <= 4'd0; active <= 1'b0; end
            else sc <= sc + 4'd1;
        end else begin
            sc <= 4'd1;
        end
    end

    int n_run = 0, n_bad = 0, steps = 0;

    task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic preset(input logic [6:0] op, input logic act, input logic [15:0] a,
                          input logic ee, input logic [15:0] d, input logic [11:0] p,
                          input logic [11:0] adr, input logic [15:0] mv);
        p_op = op; p_act = act; p_ac = a; p_e = ee; p_dr = d; p_pc = p; p_ar = adr; p_mv = mv;
        p_go = 1'b1;
        @(negedge clk);
        p_go = 1'b0;
    endtask

    task automatic run(input int bit_i, input logic [15:0] a, input logic ee,
                       input logic [11:0] p, input logic [11:0] adr, input logic [15:0] mv);
        preset(7'd1 << bit_i, 1'b1, a, ee, 16'h5A5A, p, adr, mv);
        steps = 0;
        while (active && steps < 20) begin
            @(negedge clk);
            steps++;
        end
    endtask

    task automatic t_and();
        run(0, 16'hF0F0, 1'b1, 12'h010, 12'h100, 16'h3C3C);
        chk("R1", "AND ac", ac, 16'h3030);
        chk("R1", "AND dr", dr, 16'h3C3C);
        chk("R1", "AND steps", 16'(steps), 16'd2);
        chk("R1", "AND e kept", {15'd0, e}, 16'd1);
    endtask

    task automatic t_add();
        run(1, 16'hFFFF, 1'b0, 12'h010, 12'h101, 16'h0002);
        chk("R2", "ADD wrap ac", ac, 16'h0001);
        chk("R2", "ADD wrap e", {15'd0, e}, 16'd1);
        run(1, 16'h1234, 1'b1, 12'h010, 12'h102, 16'h1111);
        chk("R2", "ADD ac", ac, 16'h2345);
        chk("R2", "ADD e cleared", {15'd0, e}, 16'd0);
        chk("R2", "ADD steps", 16'(steps), 16'd2);
    endtask

    task automatic t_lda();
        run(2, 16'h7777, 1'b1, 12'h010, 12'h103, 16'h8421);
        chk("R3", "LDA ac", ac, 16'h8421);
        chk("R3", "LDA e kept", {15'd0, e}, 16'd1);
    endtask

    task automatic t_sta();
        run(3, 16'hBEEF, 1'b0, 12'h010, 12'h123, 16'h0000);
        chk("R4", "STA mem", mem[12'h123], 16'hBEEF);
        chk("R4", "STA ac", ac, 16'hBEEF);
        chk("R4", "STA steps", 16'(steps), 16'd1);
    endtask

    task automatic t_bun();
        run(4, 16'h0000, 1'b0, 12'h010, 12'h7FE, 16'h0000);
        chk("R5", "BUN pc", {4'd0, pc}, 16'h07FE);
        chk("R5", "BUN steps", 16'(steps), 16'd1);
    endtask

    task automatic t_bsa();
        run(5, 16'h0000, 1'b0, 12'h0A5, 12'h200, 16'hFFFF);
        chk("R6", "BSA mem", mem[12'h200], 16'h00A5);
        chk("R6", "BSA pc", {4'd0, pc}, 16'h0201);
        chk("R6", "BSA ar", {4'd0, ar}, 16'h0201);
        chk("R6", "BSA steps", 16'(steps), 16'd2);
        run(5, 16'h0000, 1'b0, 12'hFFF, 12'hFFF, 16'hFFFF);
        chk("R6", "BSA top mem", mem[12'hFFF], 16'h0FFF);
        chk("R6", "BSA wrap pc", {4'd0, pc}, 16'h0000);
    endtask

    task automatic t_isz();
        run(6, 16'h0000, 1'b0, 12'h050, 12'h300, 16'hFFFF);
        chk("R7", "ISZ wrap mem", mem[12'h300], 16'h0000);
        chk("R7", "ISZ skip pc", {4'd0, pc}, 16'h0051);
        chk("R7", "ISZ steps", 16'(steps), 16'd3);
        run(6, 16'h0000, 1'b0, 12'h050, 12'h301, 16'h0007);
        chk("R7", "ISZ mem", mem[12'h301], 16'h0008);
        chk("R7", "ISZ no skip pc", {4'd0, pc}, 16'h0050);
    endtask

    task automatic t_noop();
        int hits;
        hits = 0;
        preset(7'd0, 1'b1, 16'h1357, 1'b1, 16'h2468, 12'h040, 12'h400, 16'h9999);
        for (int k = 0; k < 3; k++) begin
            if (mem_we | dr_ld | dr_inc | ac_ld | e_ld | pc_ld | pc_inc | ar_inc | sc_clr) hits++;
            @(negedge clk);
        end
        chk("R8", "noop strobes", 16'(hits), 16'd0);
        chk("R8", "noop ac", ac, 16'h1357);
        chk("R8", "noop dr", dr, 16'h2468);
        chk("R8", "noop pc", {4'd0, pc}, 16'h0040);
        chk("R8", "noop mem", mem[12'h400], 16'h9999);
        preset(7'd0, 1'b0, 16'h0, 1'b0, 16'h0, 12'h0, 12'h401, 16'h0);
    endtask

    task automatic t_abandon();
        preset(7'd1 << 1, 1'b1, 16'h1111, 1'b0, 16'h0, 12'h010, 12'h500, 16'h2222);
        // T4 of ADD has run; T0 now cuts it off
        preset(7'd0, 1'b0, 16'h1111, 1'b0, 16'h0, 12'h010, 12'h501, 16'h0);
        run(2, 16'h1111, 1'b0, 12'h010, 12'h502, 16'h4444);
        chk("R10", "abandon ac", ac, 16'h4444);
        chk("R10", "abandon e", {15'd0, e}, 16'd0);
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk);
        n_run++; n_bad++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9", "reset strobes",
            {4'd0, mem_we, dr_ld, dr_inc, ac_ld, e_ld, pc_ld, pc_inc, ar_inc, sc_clr, 3'd0}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "idle strobes", {15'd0, mem_we | dr_ld | ac_ld | pc_ld | sc_clr}, 16'd0);
        t_and();
        t_add();
        t_lda();
        t_sta();
        t_bun();
        t_bsa();
        t_isz();
        t_noop();
        t_abandon();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule